// File: doc/BRIEF.md
# BCD Calendar Clock Register Core

This block keeps wall-clock time and calendar date as eight byte-wide registers in packed BCD: seconds, minutes, hours, weekday with a century flag, date, month, two-digit year and a control byte. A one-cycle pulse on `tick` stands for one elapsed second. Each pulse advances the seconds. Carries ripple through minutes, hours, date, month and year. The date rolls over according to the length of the current month, with a leap February every fourth year.

Software uses a small register port: a 3-bit register index, a write strobe with a data byte, and a read strobe. Reads return the live counter values. Every time field write is checked digit by digit and against the legal range of its field. A write that fails the check is dropped without any report. The top bit of the seconds byte is a stop flag that freezes the count, and bit 6 of the weekday byte is a century flag that software keeps.

Top module: `bcd_rtc_core`

## Requirements
- R1: After a synchronous active-low reset the registers read: control 0x90, seconds 0x00 with the stop flag clear, minutes 0x00, hours 0x00, weekday 0 with century flag clear, date 0x01, month 0x01, year 0x00.
- R2: While `rd_en` is high, `rd_data` shows in the same cycle the register chosen by `addr` (0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year). While `rd_en` is low, `rd_data` is 0x00.
- R3: A `tick` on a running clock adds one second. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into the date.
- R4: On a date carry the date wraps to 01 after the last day of the month: 30 for April, June, September and November, 31 for the other months, and for February 29 when the binary year value is divisible by 4 and 28 otherwise. The month wraps 12 to 01 and carries into the year, and the year wraps 99 to 00.
- R5: The weekday (bits 2:0 of register 4) counts 0 to 6 and wraps to 0. It steps once on each date carry.
- R6: Bit 7 of every seconds write becomes the stop flag, whether or not the seconds value is accepted. While the flag is set, ticks are ignored. A seconds read returns the flag in bit 7 above the BCD seconds.
- R7: A seconds or minutes write keeps bits 6:0 of the data. It is stored only if both digits are 0 to 9 and the value is 00 to 59. Otherwise the field keeps its old value.
- R8: An hours write keeps bits 5:0 and accepts 00 to 23. A date write keeps bits 5:0 and accepts 01 to 31. A month write keeps bits 4:0 and accepts 01 to 12. A year write keeps all 8 bits and accepts 00 to 99. All of them also require valid BCD digits, and a rejected write leaves the field unchanged.
- R9: A weekday/century write always copies data bit 6 into the century flag, which reads back in bit 6. Data bits 2:0 become the weekday only if they are 0 to 6. All other bits of register 4 read as 0.
- R10: A control write stores the data byte with bit 5 cleared and bits 7 and 4 set.
- R11: A write takes effect at the next clock edge. A tick in the same cycle as any write strobe is discarded, so only the write changes the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle pulse per elapsed second |
| addr | input | 3 | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, 0x00 when not reading |

## Verification
A second tick and a register write can arrive in the same cycle. The block must then apply the write and drop the tick, even when the write is rejected by its range check or targets a field other than seconds. The bench provokes this case in directed form (a minutes load together with a tick while the seconds sit at 59) and also at random within the mixed stream of ticks and writes. The bench judges the result by reading back all fields and comparing them with a software calendar model that applies only the write.

// File: rtl/bcd_rtc_pkg.sv
// Package: shared register index type and BCD helper functions for the
// calendar clock core. Assumes packed two-digit BCD in a byte.
package bcd_rtc_pkg;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_SEC   = 3'd1,
        REG_MIN   = 3'd2,
        REG_HOUR  = 3'd3,
        REG_WDAY  = 3'd4,
        REG_DATE  = 3'd5,
        REG_MONTH = 3'd6,
        REG_YEAR  = 3'd7
    } rtc_reg_e;

    // True when both nibbles are decimal digits.
    function automatic logic bcd_digits_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    // True when v is valid BCD and lies in [lo, hi] (BCD order equals numeric order).
    function automatic logic bcd_in_range(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        return bcd_digits_ok(v) && (v >= lo) && (v <= hi);
    endfunction

    // Next BCD value, with a carry from the low digit into the high digit.
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

    // Binary value of a two-digit BCD byte.
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
// One BCD counting field of the calendar clock.
// Loads a pre-checked value, or steps by one when asked. After reaching
// max_val it steps back to MIN_VAL and raises roll for the next field.
// Assumes load and step are never high together (the parent drops ticks
// in write cycles).
module rtc_bcd_field
    import bcd_rtc_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h00,
    parameter logic [7:0] MIN_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       step,
    input  logic [7:0] max_val,
    output logic [7:0] value,
    output logic       roll
);

    // Carry out: a step taken at (or beyond) the top of the range.
    assign roll = step && (value >= max_val);

    // Field register: reset, load, or wrap/step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= RST_VAL;
        else if (load)
            value <= load_val;
        else if (step)
            value <= roll ? MIN_VAL : bcd_step(value);
    end

endmodule

// File: rtl/rtc_month_len.sv
// Last valid date of a month, in BCD, from BCD month and year.
// Leap rule: February has 29 days when the binary year is divisible by 4.
module rtc_month_len
    import bcd_rtc_pkg::*;
(
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_date
);

    logic [7:0] year_bin;
    logic       leap;

    assign year_bin = bcd_to_bin(year);
    assign leap     = (year_bin[1:0] == 2'b00);

    // Month length lookup.
    always_comb begin
        case (month)
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_rtc_core.sv
// Calendar clock register core: BCD time and date counters advanced by a
// once-per-second tick, with a range-checked byte register port.
// Assumes tick is a single-cycle pulse. Any write strobe discards a
// coincident tick. Reads are combinational from live registers.
module bcd_rtc_core
    import bcd_rtc_pkg::*;
#(
    parameter logic [7:0] CTRL_FORCE_SET = 8'h90,
    parameter logic [7:0] CTRL_FORCE_CLR = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data
);

    localparam logic [7:0] CTRL_RST = CTRL_FORCE_SET & ~CTRL_FORCE_CLR;
    localparam logic [2:0] WDAY_LAST = 3'd6;

    logic [7:0] ctrl_q, sec_q, min_q, hour_q, date_q, month_q, year_q;
    logic [2:0] wday_q;
    logic       stop_q, cent_q;
    logic [7:0] last_date;

    logic       tick_en;
    logic       sec_roll, min_roll, hour_roll, date_roll, month_roll, year_roll;
    logic [7:0] sec_in, min_in, hour_in, date_in, month_in;
    logic       ld_sec, ld_min, ld_hour, ld_date, ld_month, ld_year, ld_wday;

    // Second enable: running clock and no write in this cycle.
    assign tick_en = tick && !stop_q && !wr_en;

    // Masked write data per field.
    assign sec_in   = {1'b0, wr_data[6:0]};
    assign min_in   = {1'b0, wr_data[6:0]};
    assign hour_in  = {2'b00, wr_data[5:0]};
    assign date_in  = {2'b00, wr_data[5:0]};
    assign month_in = {3'b000, wr_data[4:0]};

    // Write decode with per-field range check.
    always_comb begin
        ld_sec   = wr_en && (addr == REG_SEC)   && bcd_in_range(sec_in,   8'h00, 8'h59);
        ld_min   = wr_en && (addr == REG_MIN)   && bcd_in_range(min_in,   8'h00, 8'h59);
        ld_hour  = wr_en && (addr == REG_HOUR)  && bcd_in_range(hour_in,  8'h00, 8'h23);
        ld_date  = wr_en && (addr == REG_DATE)  && bcd_in_range(date_in,  8'h01, 8'h31);
        ld_month = wr_en && (addr == REG_MONTH) && bcd_in_range(month_in, 8'h01, 8'h12);
        ld_year  = wr_en && (addr == REG_YEAR)  && bcd_in_range(wr_data,  8'h00, 8'h99);
        ld_wday  = wr_en && (addr == REG_WDAY)  && (wr_data[2:0] <= WDAY_LAST);
    end

    rtc_month_len u_mlen (
        .month     (month_q),
        .year      (year_q),
        .last_date (last_date)
    );

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .load(ld_sec), .load_val(sec_in),
        .step(tick_en), .max_val(8'h59), .value(sec_q), .roll(sec_roll));

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .load(ld_min), .load_val(min_in),
        .step(sec_roll), .max_val(8'h59), .value(min_q), .roll(min_roll));

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_hour (
        .clk(clk), .rst_n(rst_n), .load(ld_hour), .load_val(hour_in),
        .step(min_roll), .max_val(8'h23), .value(hour_q), .roll(hour_roll));

    rtc_bcd_field #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_date (
        .clk(clk), .rst_n(rst_n), .load(ld_date), .load_val(date_in),
        .step(hour_roll), .max_val(last_date), .value(date_q), .roll(date_roll));

    rtc_bcd_field #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_month (
        .clk(clk), .rst_n(rst_n), .load(ld_month), .load_val(month_in),
        .step(date_roll), .max_val(8'h12), .value(month_q), .roll(month_roll));

    rtc_bcd_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .load(ld_year), .load_val(wr_data),
        .step(month_roll), .max_val(8'h99), .value(year_q), .roll(year_roll));

    // Weekday counter, stepped by the date carry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wday_q <= 3'd0;
        else if (ld_wday)
            wday_q <= wr_data[2:0];
        else if (hour_roll)
            wday_q <= (wday_q >= WDAY_LAST) ? 3'd0 : wday_q + 3'd1;
    end

    // Stop flag, century flag and control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            cent_q <= 1'b0;
            ctrl_q <= CTRL_RST;
        end else if (wr_en) begin
            if (addr == REG_SEC)  stop_q <= wr_data[7];
            if (addr == REG_WDAY) cent_q <= wr_data[6];
            if (addr == REG_CTRL) ctrl_q <= (wr_data & ~CTRL_FORCE_CLR) | CTRL_FORCE_SET;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            case (addr)
                REG_CTRL:  rd_data = ctrl_q;
                REG_SEC:   rd_data = {stop_q, sec_q[6:0]};
                REG_MIN:   rd_data = min_q;
                REG_HOUR:  rd_data = hour_q;
                REG_WDAY:  rd_data = {1'b0, cent_q, 3'b000, wday_q};
                REG_DATE:  rd_data = date_q;
                REG_MONTH: rd_data = month_q;
                default:   rd_data = year_q;
            endcase
        end
    end

    // Year carry has no further consumer.
    logic unused_ok;
    assign unused_ok = year_roll;

endmodule

// File: rtl/rtc_core_checker.sv
// Checker for the calendar clock core: register invariants and
// write/tick interactions. Attached to bcd_rtc_core by bind below.
module rtc_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wr_data,
    input logic [7:0] ctrl_q,
    input logic       stop_q,
    input logic [7:0] sec_q,
    input logic [7:0] hour_q,
    input logic [7:0] month_q,
    input logic [2:0] wday_q
);

    // R10: forced control bits always hold.
    assert_ctrl_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);

    // R7: seconds stay a valid BCD value 00..59.
    assert_sec_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[3:0] <= 4'd9) && (sec_q <= 8'h59));

    // R8: hours and month stay within their ranges.
    assert_hour_month_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_q[3:0] <= 4'd9) && (hour_q <= 8'h23) &&
        (month_q >= 8'h01) && (month_q <= 8'h12) && (month_q[3:0] <= 4'd9));

    // R5: weekday never exceeds 6.
    assert_wday_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wday_q <= 3'd6);

    // R6: with the stop flag set and no write, seconds hold.
    assert_stop_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !wr_en) |=> $stable(sec_q));

    // R6: seconds write sets the stop flag from data bit 7.
    assert_stop_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1) |=> (stop_q == $past(wr_data[7])));

    // R11: a tick alongside a write to another register leaves seconds alone.
    assert_tick_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wr_en && addr != 3'd1) |=> $stable(sec_q));

endmodule

bind bcd_rtc_core rtc_core_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .stop_q  (stop_q),
    .sec_q   (sec_q),
    .hour_q  (hour_q),
    .month_q (month_q),
    .wday_q  (wday_q)
);

// File: tb/bcd_rtc_core_test.sv
// Bench: directed corners plus seeded random ticks/writes, checked by
// reading every register and comparing with a software calendar model.
module bcd_rtc_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model state, kept in binary.
    int m_sec, m_min, m_hour, m_wday, m_date, m_mon, m_year;
    bit m_stop, m_cent;
    logic [7:0] m_ctrl;

    always #5 clk = ~clk;

    bcd_rtc_core uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    // Binary value of BCD byte, or -1 when a digit is not decimal.
    function automatic int dec(input logic [7:0] v);
        if (v[7:4] > 4'd9 || v[3:0] > 4'd9) return -1;
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic int mdays(input int mo, input int yr);
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    function automatic logic [7:0] exp_reg(input int a);
        case (a)
            0: return m_ctrl;
            1: return {m_stop, to_bcd(m_sec)[6:0]};
            2: return to_bcd(m_min);
            3: return to_bcd(m_hour);
            4: return {1'b0, m_cent, 3'b000, 3'(m_wday)};
            5: return to_bcd(m_date);
            6: return to_bcd(m_mon);
            default: return to_bcd(m_year);
        endcase
    endfunction

    task automatic model_tick();
        if (m_stop) return;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hour++;
        if (m_hour < 24) return;
        m_hour = 0;
        m_wday = (m_wday + 1) % 7;
        m_date++;
        if (m_date <= mdays(m_mon, m_year)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1;
        m_year = (m_year + 1) % 100;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        int v;
        case (a)
            0: m_ctrl = (d & 8'hDF) | 8'h90;
            1: begin
                m_stop = d[7];
                v = dec(d & 8'h7F);
                if (v >= 0 && v <= 59) m_sec = v;
            end
            2: begin v = dec(d & 8'h7F); if (v >= 0 && v <= 59) m_min = v; end
            3: begin v = dec(d & 8'h3F); if (v >= 0 && v <= 23) m_hour = v; end
            4: begin
                m_cent = d[6];
                if (int'(d[2:0]) <= 6) m_wday = int'(d[2:0]);
            end
            5: begin v = dec(d & 8'h3F); if (v >= 1 && v <= 31) m_date = v; end
            6: begin v = dec(d & 8'h1F); if (v >= 1 && v <= 12) m_mon = v; end
            default: begin v = dec(d); if (v >= 0 && v <= 99) m_year = v; end
        endcase
    endtask

    // One bus cycle: optional tick and/or write, then model update.
    task automatic op(input bit t, input bit w, input int a, input logic [7:0] d);
        @(negedge clk);
        tick = t; wr_en = w; addr = 3'(a); wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        if (w) model_write(a, d);
        else if (t) model_tick();
    endtask

    task automatic check_reg(input int a, input string req);
        logic [7:0] e;
        @(negedge clk);
        rd_en = 1'b1; addr = 3'(a);
        #1;
        e = exp_reg(a);
        n_run++;
        if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s reg %0d: actual %02h expected %02h", req, a, rd_data, e);
        end
        rd_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 8; a++) check_reg(a, req);
    endtask

    task automatic set_time(input int yr, input int mo, input int dt,
                            input int hr, input int mi, input int se);
        op(0, 1, 7, to_bcd(yr));
        op(0, 1, 6, to_bcd(mo));
        op(0, 1, 5, to_bcd(dt));
        op(0, 1, 3, to_bcd(hr));
        op(0, 1, 2, to_bcd(mi));
        op(0, 1, 1, to_bcd(se));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual still running, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240601));
        m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0;
        m_date = 1; m_mon = 1; m_year = 0;
        m_stop = 1'b0; m_cent = 1'b0; m_ctrl = 8'h90;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of all registers.
        check_all("R1");

        // R2: read data is zero without the read strobe.
        @(negedge clk);
        addr = 3'd6; rd_en = 1'b0;
        #1;
        n_run++;
        if (rd_data !== 8'h00) begin
            n_fail++;
            $display("FAIL R2 idle read: actual %02h expected 00", rd_data);
        end

        // R10: control forced bits.
        op(0, 1, 0, 8'h2F);
        check_reg(0, "R10");
        op(0, 1, 0, 8'h00);
        check_reg(0, "R10");

        // R3: carry chain from seconds to the date, and the weekday step (R5).
        set_time(10, 6, 15, 23, 59, 58);
        op(0, 1, 4, 8'h05);
        op(1, 0, 0, 8'h00);
        check_reg(1, "R3");
        op(1, 0, 0, 8'h00);
        check_all("R3");

        // R5: weekday 6 wraps to 0 on a date carry.
        set_time(10, 6, 16, 23, 59, 59);
        op(0, 1, 4, 8'h06);
        op(1, 0, 0, 8'h00);
        check_reg(4, "R5");

        // R4: leap February, non-leap February, end of year.
        set_time(24, 2, 28, 23, 59, 59);
        op(1, 0, 0, 8'h00);
        check_reg(5, "R4");
        set_time(24, 2, 29, 23, 59, 59);
        op(1, 0, 0, 8'h00);
        check_all("R4");
        set_time(23, 2, 28, 23, 59, 59);
        op(1, 0, 0, 8'h00);
        check_all("R4");
        set_time(99, 12, 31, 23, 59, 59);
        op(1, 0, 0, 8'h00);
        check_all("R4");
        set_time(10, 4, 30, 23, 59, 59);
        op(1, 0, 0, 8'h00);
        check_all("R4");

        // R6: stop flag freezes seconds, clearing it resumes.
        op(0, 1, 1, 8'hB0);
        repeat (3) op(1, 0, 0, 8'h00);
        check_reg(1, "R6");
        op(0, 1, 1, 8'h30);
        op(1, 0, 0, 8'h00);
        check_reg(1, "R6");
        op(0, 1, 1, 8'hE0);
        check_reg(1, "R6");

        // R7: rejected and masked seconds/minutes writes.
        op(0, 1, 1, 8'h60);
        check_reg(1, "R7");
        op(0, 1, 1, 8'h5A);
        check_reg(1, "R7");
        op(0, 1, 2, 8'hC5);
        check_reg(2, "R7");

        // R8: hours, date, month, year limits and masks.
        op(0, 1, 3, 8'h24);
        check_reg(3, "R8");
        op(0, 1, 3, 8'h63);
        check_reg(3, "R8");
        op(0, 1, 6, 8'h13);
        op(0, 1, 6, 8'h00);
        check_reg(6, "R8");
        op(0, 1, 6, 8'h2C);
        check_reg(6, "R8");
        op(0, 1, 5, 8'h32);
        op(0, 1, 5, 8'h00);
        check_reg(5, "R8");
        op(0, 1, 7, 8'hA0);
        check_reg(7, "R8");

        // R9: century always stored, weekday 7 rejected.
        op(0, 1, 4, 8'h03);
        op(0, 1, 4, 8'hC7);
        check_reg(4, "R9");

        // R11: tick with a write in the same cycle is discarded.
        set_time(10, 6, 15, 12, 30, 59);
        op(1, 1, 2, 8'h10);
        check_all("R11");
        op(1, 1, 3, 8'h99);
        check_all("R11");

        // Random mix of ticks, writes and coincident pairs.
        for (int i = 0; i < 4000; i++) begin
            int kind = int'($urandom % 20);
            int a = int'($urandom % 8);
            logic [7:0] d = ($urandom % 2 == 1) ? to_bcd(int'($urandom % 100)) : 8'($urandom);
            if (a == 1 && ($urandom % 4) != 0) d[7] = 1'b0;
            if (kind < 14)      op(1, 0, 0, 8'h00);
            else if (kind < 19) op(0, 1, a, d);
            else                op(1, 1, a, d);
            check_reg(int'($urandom % 8), "R11");
            if (i % 200 == 199) check_all("R3");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule